// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces, one beat per clock, the column addresses that a synchronous DRAM burst visits. A burst begins when a start pulse is sampled together with a starting column, a length code, an ordering choice and a direction. From then on the block presents the column of each beat, a flag that the beat is valid, and a flag that marks the final beat of a fixed-length burst.

Two orderings are supported. Sequential order counts up in the low bits of the column and wraps inside the aligned block that the burst length defines. Interleaved order XORs the beat number into those same low bits. A page-length burst ignores the ordering, walks every column of the row with wrap to zero, and runs until a terminate strobe arrives. A single-write mode keeps reads at the programmed length while cutting every write to one beat. The same block can sit in a memory model or in a controller to map each data beat to its column.

Top module: `sdr_burst_colgen`

## Requirements
- R1: While `rst` is high on a rising edge, the next cycle shows `valid_o` = 0 and `last_o` = 0.
- R2: A rising edge that samples `start_i` = 1 starts a burst: in the following cycle `valid_o` = 1 and `col_o` equals the sampled `start_col_i`. With no burst active and no start, `valid_o` stays 0.
- R3: `bl_code_i` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives a page-length burst; codes 4, 5 and 6 give a single beat.
- R4: With `bt_ileave_i` = 0 and a fixed length L, beat n shows the start column with its low log2(L) bits replaced by (start low bits + n) mod L; the upper bits keep the start value.
- R5: With `bt_ileave_i` = 1 and a fixed length L, beat n shows the start column with its low log2(L) bits XORed with n.
- R6: A page-length burst shows (start + n) mod 2^COL_W on beat n regardless of `bt_ileave_i`, never raises `last_o`, and continues until terminated or restarted.
- R7: `last_o` is 1 exactly on the final beat of a fixed-length burst; on the next edge without a start, `valid_o` drops to 0.
- R8: A rising edge that samples `term_i` = 1 while a burst is valid and `start_i` = 0 ends the burst: `valid_o` is 0 in the following cycle.
- R9: When `wsingle_i` = 1 and `is_write_i` = 1 at the start, the burst is one beat with `last_o` = 1; a read with `wsingle_i` = 1, or a write with `wsingle_i` = 0, uses the programmed length.
- R10: A start sampled while a burst is active, including on its last beat or together with `term_i`, discards the old burst and begins the new one as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new burst with the values sampled on this edge |
| start_col_i | input | COL_W | First column of the burst |
| bl_code_i | input | 3 | Burst length code |
| bt_ileave_i | input | 1 | 1 selects interleaved order, 0 sequential |
| wsingle_i | input | 1 | 1 forces writes to a single beat |
| is_write_i | input | 1 | 1 marks the starting burst as a write |
| term_i | input | 1 | Ends the active burst at this edge |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A burst beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The collisions of interest are a new start landing in the same cycle as either a terminate strobe or the final beat of a running burst, where the start must win and the old burst must leave no trace. The bench provokes both by raising `start_i` together with `term_i` mid-burst, and by raising it exactly on the cycle where `last_o` is expected. A behavioural model, updated on every edge from the same inputs, judges each cycle by comparing the column, valid and last flags, so a wrong priority shows up as a stale column or a dropped valid on the very next beat.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

  // Length codes whose value matters to the decode
  localparam logic [2:0] BLC_1    = 3'd0;
  localparam logic [2:0] BLC_2    = 3'd1;
  localparam logic [2:0] BLC_4    = 3'd2;
  localparam logic [2:0] BLC_8    = 3'd3;
  localparam logic [2:0] BLC_PAGE = 3'd7;

  // Ordering held for the life of a burst
  typedef enum logic [1:0] {
    ORD_SEQ   = 2'd0,
    ORD_ILV   = 2'd1,
    ORD_PAGE  = 2'd2
  } burst_order_e;

  // log2 of the fixed length for a code; reserved codes give one beat
  function automatic logic [1:0] blc_log2(input logic [2:0] code);
    case (code)
      BLC_2:   blc_log2 = 2'd1;
      BLC_4:   blc_log2 = 2'd2;
      BLC_8:   blc_log2 = 2'd3;
      default: blc_log2 = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sdr_bl_decode.sv
module sdr_bl_decode
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       bl_code_i,
  input  logic             bt_ileave_i,
  input  logic             wsingle_i,
  input  logic             is_write_i,
  output logic [COL_W-1:0] mask_o,
  output burst_order_e     order_o,
  output logic             one_beat_o
);

  logic       single_w;
  logic       page_w;
  logic [1:0] lg_w;

  always_comb begin
    single_w = wsingle_i & is_write_i;
    page_w   = (bl_code_i == BLC_PAGE) & ~single_w;
    lg_w     = single_w ? 2'd0 : blc_log2(bl_code_i);
    if (page_w)
      order_o = ORD_PAGE;
    else if (bt_ileave_i)
      order_o = ORD_ILV;
    else
      order_o = ORD_SEQ;
  end

  // One mask bit per column bit: set when the bit lies inside the burst block
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = page_w | (int'(lg_w) > i);
  end

  assign one_beat_o = ~page_w & (lg_w == 2'd0);

endmodule

// File: rtl/sdr_col_step.sv
module sdr_col_step
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  burst_order_e     order_i,
  output logic [COL_W-1:0] col_nxt_o,
  output logic [COL_W-1:0] beat_nxt_o,
  output logic             last_nxt_o
);

  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] ilv_low;
  logic [COL_W-1:0] low_sel;

  always_comb begin
    beat_nxt_o = beat_i + COL_W'(1);
    seq_low    = (col_i + COL_W'(1)) & mask_i;
    ilv_low    = (base_i ^ beat_nxt_o) & mask_i;
    low_sel    = (order_i == ORD_ILV) ? ilv_low : seq_low;
    col_nxt_o  = (base_i & ~mask_i) | low_sel;
    last_nxt_o = (order_i != ORD_PAGE) && ((beat_nxt_o & mask_i) == mask_i);
  end

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             bt_ileave_i,
  input  logic             wsingle_i,
  input  logic             is_write_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic [COL_W-1:0] dec_mask;
  burst_order_e     dec_order;
  logic             dec_one;

  logic [COL_W-1:0] base_q, col_q, beat_q, mask_q;
  burst_order_e     order_q;
  logic             valid_q, last_q;

  logic [COL_W-1:0] col_nxt, beat_nxt;
  logic             last_nxt;

  sdr_bl_decode #(.COL_W(COL_W)) u_dec (
    .bl_code_i   (bl_code_i),
    .bt_ileave_i (bt_ileave_i),
    .wsingle_i   (wsingle_i),
    .is_write_i  (is_write_i),
    .mask_o      (dec_mask),
    .order_o     (dec_order),
    .one_beat_o  (dec_one)
  );

  sdr_col_step #(.COL_W(COL_W)) u_step (
    .base_i     (base_q),
    .col_i      (col_q),
    .beat_i     (beat_q),
    .mask_i     (mask_q),
    .order_i    (order_q),
    .col_nxt_o  (col_nxt),
    .beat_nxt_o (beat_nxt),
    .last_nxt_o (last_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      col_q   <= '0;
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      order_q <= ORD_SEQ;
    end else if (start_i) begin
      valid_q <= 1'b1;
      last_q  <= dec_one;
      col_q   <= start_col_i;
      base_q  <= start_col_i;
      beat_q  <= '0;
      mask_q  <= dec_mask;
      order_q <= dec_order;
    end else if (valid_q) begin
      if (term_i || last_q) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end else begin
        col_q  <= col_nxt;
        beat_q <= beat_nxt;
        last_q <= last_nxt;
      end
    end
  end

  assign col_o   = col_q;
  assign valid_o = valid_q;
  assign last_o  = last_q;

endmodule

// File: rtl/sdr_burst_colgen_chk.sv
module sdr_burst_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(start_col_i))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !start_i) |=> !valid_o); // R2

  AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o); // R7

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    (valid_o && last_o && !start_i) |=> !valid_o); // R7

  AST_TERM_ENDS: assert property (@(posedge clk) disable iff (rst)
    (valid_o && term_i && !start_i) |=> !valid_o); // R8

endmodule

bind sdr_burst_colgen sdr_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/sdr_burst_colgen_bench.sv
`timescale 1ns/1ps
module sdr_burst_colgen_bench;

  localparam int COL_W = 8;
  localparam int NCOL  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       bl_code_i = 3'd0;
  logic             bt_ileave_i = 1'b0;
  logic             wsingle_i = 1'b0;
  logic             is_write_i = 1'b0;
  logic             term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit m_act = 0;
  int m_base = 0, m_n = 0, m_len = 1;
  bit m_ilv = 0;

  always #2.5 clk = ~clk;

  sdr_burst_colgen #(.COL_W(COL_W)) u_sdr_burst_colgen (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .bt_ileave_i(bt_ileave_i), .wsingle_i(wsingle_i),
    .is_write_i(is_write_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int code_len(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int blk, lo;
    if (m_len == 0) return (m_base + m_n) % NCOL;
    blk = m_base - (m_base % m_len);
    lo  = m_base % m_len;
    if (m_ilv) return blk + (lo ^ m_n);
    return blk + ((lo + m_n) % m_len);
  endfunction

  task automatic model_edge();
    if (rst) m_act = 0;
    else if (start_i) begin
      m_act  = 1;
      m_base = int'(start_col_i);
      m_n    = 0;
      m_len  = (wsingle_i && is_write_i) ? 1 : code_len(int'(bl_code_i));
      m_ilv  = bt_ileave_i;
    end else if (m_act) begin
      if (term_i) m_act = 0;
      else if (m_len != 0 && m_n == m_len - 1) m_act = 0;
      else m_n++;
    end
  endtask

  task automatic check1(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // one clock: model follows the sampled inputs, outputs compared mid-cycle
  task automatic cyc(input string tag);
    bit elast;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (done) return;
    elast = m_act && m_len != 0 && m_n == m_len - 1;
    check1(tag, "valid", int'(valid_o), int'(m_act));
    check1(tag, "last", int'(last_o), int'(elast));
    if (m_act) check1(tag, "col", int'(col_o), exp_col());
  endtask

  task automatic go(input int col, input int code, input bit ilv,
                    input bit wr, input bit ws, input string tag, input int n);
    start_i = 1; start_col_i = COL_W'(col); bl_code_i = 3'(code);
    bt_ileave_i = ilv; is_write_i = wr; wsingle_i = ws;
    cyc(tag);
    start_i = 0;
    repeat (n) cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      done = 1;
      $finish;
    end
  end

  initial begin
    cyc("R1"); cyc("R1");
    rst = 0;
    cyc("R2");
    // R3 / R4: sequential, every fixed length
    go(8'h35, 3, 0, 0, 0, "R4", 9);
    go(8'h0E, 2, 0, 0, 0, "R4", 5);
    go(8'h7F, 1, 0, 0, 0, "R3", 3);
    go(8'h22, 0, 0, 0, 0, "R3", 2);
    go(8'h91, 5, 0, 0, 0, "R3", 2);
    go(8'h93, 4, 1, 0, 0, "R3", 2);
    // R5: interleaved
    go(8'h35, 3, 1, 0, 0, "R5", 9);
    go(8'h0B, 2, 1, 0, 0, "R5", 5);
    go(8'hC3, 1, 1, 0, 0, "R5", 3);
    // R6: page burst wraps past 0, interleave ignored, then terminated (R8)
    go(8'hFC, 7, 1, 0, 0, "R6", 260);
    term_i = 1; cyc("R8"); term_i = 0;
    cyc("R6"); cyc("R6");
    // R8: terminate mid fixed burst
    go(8'h40, 3, 0, 0, 0, "R8", 3);
    term_i = 1; cyc("R8"); term_i = 0; cyc("R8");
    // R9: single-write mode
    go(8'h57, 3, 0, 1, 1, "R9", 2);
    go(8'h57, 7, 0, 1, 1, "R9", 2);
    go(8'h57, 2, 1, 0, 1, "R9", 5);
    go(8'h57, 2, 0, 1, 0, "R9", 5);
    // R10: restarts
    go(8'h10, 3, 0, 0, 0, "R10", 3);
    go(8'h47, 2, 1, 0, 0, "R10", 2);
    term_i = 1;
    go(8'hA6, 3, 0, 0, 0, "R10", 0);
    term_i = 0;
    repeat (3) cyc("R10");
    go(8'h31, 1, 0, 0, 0, "R10", 1);
    go(8'h62, 2, 0, 0, 0, "R10", 5);
    // R1: reset in mid burst
    go(8'h20, 7, 0, 0, 0, "R6", 4);
    rst = 1; cyc("R1"); rst = 0; cyc("R1");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule